// File: doc/BRIEF.md
# Prioritised Interrupt Distributor for Two CPUs

This block collects up to 96 interrupt sources and presents to each of two processors a single request line and the number of the most urgent interrupt that processor may take. Every source has its own enable bit, a pending flag, a trigger-mode field, an 8-bit priority and a CPU-target byte. Software reaches all of this state through a small word-addressed register bus.

Source numbers are split into four classes. Numbers 0–15 are software interrupts raised only by a bus write. Numbers 16–26 are unused and never become pending. Numbers 27–31 are per-processor sources, and 32–95 are shared peripheral lines. A global switch gates all forwarding. Each processor also has its own interface enable and a priority threshold. The block does no acknowledge, active-state or end-of-interrupt handling. It shows only the current winner for each processor.

Register map, in word addresses: 0x00 global control (bit 0 = forward enable); 0x04+c interface enable of CPU c (bit 0); 0x08+c priority threshold of CPU c (bits 7:0); 0x0C software-interrupt trigger; 0x10+w set-enable; 0x14+w clear-enable; 0x18+w clear-pending; 0x1C+w pending status (read-only), where word w holds sources 32w..32w+31 at bit (n mod 32); 0x20+n/16 trigger fields, 2 bits at bit 2(n mod 16); 0x40+n/4 priorities and 0x60+n/4 targets, one byte at bit 8(n mod 4).

Top module: `irq_distributor`

## Requirements
- R1: After reset every enable, pending flag, configuration field, threshold and control bit is zero, both request outputs are low and both ID outputs are 0.
- R2: Writing 1 to a set-enable bit enables that source and writing 1 to the same bit of the clear-enable word disables it. Zero bits in either write change nothing. Reading either bank returns the current enable state.
- R3: When bit 1 of a source's 2-bit trigger field is 1, the source is edge-triggered: a low-to-high change on its line sets pending, and pending stays set after the line falls. When that bit is 0, the source is level-triggered: pending is set on every clock the line is high.
- R4: Writing 1 to a clear-pending bit clears that flag, and a 0 bit has no effect. If the same clock also sets the flag, the set wins. Sources 16–26 never become pending, and input lines 0–15 are ignored.
- R5: A write to word 0x0C sets pending for the software source given by bits 3:0 and records bits 17:16 as its routing (bit 16 = CPU0, bit 17 = CPU1). This routing replaces the target byte for sources 0–15.
- R6: While bit 0 of word 0x00 is 0, no request output is asserted.
- R7: A CPU's request output is asserted only while bit 0 of its interface-enable word is 1.
- R8: A source can be signalled to a CPU only if its priority value is strictly less than that CPU's threshold.
- R9: Among the sources that are pending, enabled, targeted at the CPU and below its threshold, the one with the numerically lowest priority wins. Ties go to the lowest source number. The winner's number appears on that CPU's ID output.
- R10: For sources 27–95, bit 0 of the target byte routes the source to CPU0 and bit 1 routes it to CPU1.
- R11: A read presents data on the clock edge at which the read strobe is sampled, so the data is valid in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 96 | Hardware interrupt lines, one per source |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| cpu_irq | output | 2 | Request line per CPU |
| cpu_id | output | 14 | Winning source number, 7 bits per CPU (CPU0 in bits 6:0) |

## Verification
The hardest case to reach is a priority tie between two sources that are both eligible for one CPU, while a third, more urgent source is routed only to the other CPU. A software interrupt then pre-empts one CPU's choice and is cleared again. The bench builds this up in steps. It holds several level-triggered lines high, programs identical priorities and split target bytes, and only then sets the thresholds and enables. Each CPU's ID can then be checked against a single known winner, both before and after a software interrupt with a one-sided route is raised and cleared.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int PRIO_W   = 8;
  localparam int WORD_W   = 32;
  // word addresses of the register groups
  localparam int A_CTL    = 'h00;
  localparam int A_CPUEN  = 'h04;
  localparam int A_PMASK  = 'h08;
  localparam int A_SGI    = 'h0C;
  localparam int A_SETEN  = 'h10;
  localparam int A_CLREN  = 'h14;
  localparam int A_CLRPND = 'h18;
  localparam int A_PEND   = 'h1C;
  localparam int A_CFG    = 'h20;
  localparam int A_PRIO   = 'h40;
  localparam int A_TGT    = 'h60;

  // a source is allowed past a CPU threshold only when strictly more urgent
  function automatic logic passes_mask(input logic [PRIO_W-1:0] p, input logic [PRIO_W-1:0] m);
    return p < m;
  endfunction

  // strict compare keeps the earlier (lower-numbered) source on a tie
  function automatic logic beats(input logic [PRIO_W-1:0] cand, input logic [PRIO_W-1:0] best,
                                 input logic have_best);
    return !have_best || (cand < best);
  endfunction
endpackage

// File: rtl/irqd_pending.sv
module irqd_pending #(
  parameter int N      = 96,
  parameter int SGI_N  = 16,
  parameter int RSV_LO = 16,
  parameter int RSV_HI = 26
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_in,
  input  logic [N-1:0] edge_mode,
  input  logic [N-1:0] sw_set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pending
);
  logic [N-1:0] line_q;
  logic [N-1:0] set_ev;

  for (genvar i = 0; i < N; i++) begin : g_src
    if (i >= RSV_LO && i <= RSV_HI) begin : g_rsv
      assign set_ev[i] = 1'b0;
    end else if (i < SGI_N) begin : g_sw
      assign set_ev[i] = sw_set[i];
    end else begin : g_hw
      assign set_ev[i] = edge_mode[i] ? (line_in[i] & ~line_q[i]) : line_in[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q  <= '0;
      pending <= '0;
    end else begin
      line_q  <= line_in;
      pending <= (pending & ~clr) | set_ev;
    end
  end
endmodule

// File: rtl/irqd_arbiter.sv
module irqd_arbiter
  import irqd_pkg::*;
#(
  parameter int N    = 96,
  parameter int ID_W = $clog2(N)
) (
  input  logic [N-1:0]             elig,
  input  logic [N-1:0][PRIO_W-1:0] prio,
  output logic                     any,
  output logic [ID_W-1:0]          win_id,
  output logic [PRIO_W-1:0]        win_prio
);
  always_comb begin
    any      = 1'b0;
    win_id   = '0;
    win_prio = '1;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && beats(prio[i], win_prio, any)) begin
        any      = 1'b1;
        win_id   = ID_W'(i);
        win_prio = prio[i];
      end
    end
  end
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
  import irqd_pkg::*;
#(
  parameter int NUM_IRQ = 96,
  parameter int NUM_CPU = 2,
  parameter int SGI_N   = 16,
  parameter int RSV_LO  = 16,
  parameter int RSV_HI  = 26,
  parameter int ADDR_W  = 8,
  localparam int ID_W   = $clog2(NUM_IRQ)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_IRQ-1:0]        irq_in,
  input  logic                      bus_we,
  input  logic                      bus_re,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [WORD_W-1:0]         bus_wdata,
  output logic [WORD_W-1:0]         bus_rdata,
  output logic [NUM_CPU-1:0]        cpu_irq,
  output logic [NUM_CPU*ID_W-1:0]   cpu_id
);
  localparam int SGI_SEL_W = $clog2(SGI_N);

  logic                              dist_en;
  logic [NUM_CPU-1:0]                cpu_if_en;
  logic [NUM_CPU-1:0][PRIO_W-1:0]    pmask;
  logic [NUM_IRQ-1:0]                enable;
  logic [NUM_IRQ-1:0][1:0]           cfg;
  logic [NUM_IRQ-1:0][PRIO_W-1:0]    prio;
  logic [NUM_IRQ-1:0][7:0]           tgt;
  logic [SGI_N-1:0][NUM_CPU-1:0]     sgi_route;
  logic [NUM_IRQ-1:0]                pending;
  logic [NUM_IRQ-1:0]                clr_pend;
  logic [NUM_IRQ-1:0]                sw_set;
  logic [NUM_IRQ-1:0]                edge_mode;
  logic [NUM_IRQ-1:0][NUM_CPU-1:0]   route;
  logic [NUM_CPU-1:0]                win_any;
  logic [NUM_CPU-1:0][ID_W-1:0]      win_id;
  logic [NUM_CPU-1:0][PRIO_W-1:0]    win_prio;
  logic [WORD_W-1:0]                 rd_word;
  int                                a;

  assign a = int'(bus_addr);

  // write-strobe decode for the pulse-style banks
  always_comb begin
    for (int i = 0; i < NUM_IRQ; i++) begin
      clr_pend[i]  = bus_we && (a == A_CLRPND + i/32) && bus_wdata[i%32];
      sw_set[i]    = bus_we && (a == A_SGI) && (i < SGI_N) &&
                     (int'(bus_wdata[SGI_SEL_W-1:0]) == i);
      edge_mode[i] = cfg[i][1];
      if (i < SGI_N) route[i] = sgi_route[i];
      else           route[i] = tgt[i][NUM_CPU-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dist_en   <= 1'b0;
      cpu_if_en <= '0;
      pmask     <= '0;
      enable    <= '0;
      cfg       <= '0;
      prio      <= '0;
      tgt       <= '0;
      sgi_route <= '0;
    end else if (bus_we) begin
      if (a == A_CTL) dist_en <= bus_wdata[0];
      for (int c = 0; c < NUM_CPU; c++) begin
        if (a == A_CPUEN + c) cpu_if_en[c] <= bus_wdata[0];
        if (a == A_PMASK + c) pmask[c]     <= bus_wdata[PRIO_W-1:0];
      end
      for (int s = 0; s < SGI_N; s++)
        if (a == A_SGI && int'(bus_wdata[SGI_SEL_W-1:0]) == s)
          sgi_route[s] <= bus_wdata[16 +: NUM_CPU];
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (a == A_SETEN + i/32 && bus_wdata[i%32]) enable[i] <= 1'b1;
        if (a == A_CLREN + i/32 && bus_wdata[i%32]) enable[i] <= 1'b0;
        if (a == A_CFG  + i/16) cfg[i]  <= bus_wdata[(i%16)*2 +: 2];
        if (a == A_PRIO + i/4)  prio[i] <= bus_wdata[(i%4)*8 +: PRIO_W];
        if (a == A_TGT  + i/4)  tgt[i]  <= bus_wdata[(i%4)*8 +: 8];
      end
    end
  end

  irqd_pending #(.N(NUM_IRQ), .SGI_N(SGI_N), .RSV_LO(RSV_LO), .RSV_HI(RSV_HI)) u_pend (
    .clk(clk), .rst_n(rst_n), .line_in(irq_in), .edge_mode(edge_mode),
    .sw_set(sw_set), .clr(clr_pend), .pending(pending)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_IRQ-1:0] elig;
    always_comb
      for (int i = 0; i < NUM_IRQ; i++)
        elig[i] = dist_en && pending[i] && enable[i] && route[i][c] &&
                  passes_mask(prio[i], pmask[c]);
    irqd_arbiter #(.N(NUM_IRQ), .ID_W(ID_W)) u_arb (
      .elig(elig), .prio(prio), .any(win_any[c]),
      .win_id(win_id[c]), .win_prio(win_prio[c])
    );
    assign cpu_irq[c]               = win_any[c] && cpu_if_en[c];
    assign cpu_id[c*ID_W +: ID_W]   = cpu_irq[c] ? win_id[c] : '0;
  end

  // read mux, registered on the read strobe
  always_comb begin
    rd_word = '0;
    if (a == A_CTL) rd_word[0] = dist_en;
    for (int c = 0; c < NUM_CPU; c++) begin
      if (a == A_CPUEN + c) rd_word[0] = cpu_if_en[c];
      if (a == A_PMASK + c) rd_word[PRIO_W-1:0] = pmask[c];
    end
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (a == A_SETEN + i/32 || a == A_CLREN + i/32) rd_word[i%32] = enable[i];
      if (a == A_PEND + i/32) rd_word[i%32] = pending[i];
      if (a == A_CFG  + i/16) rd_word[(i%16)*2 +: 2] = cfg[i];
      if (a == A_PRIO + i/4)  rd_word[(i%4)*8 +: PRIO_W] = prio[i];
      if (a == A_TGT  + i/4)  rd_word[(i%4)*8 +: 8] = tgt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_word;
  end
endmodule

// File: rtl/irqd_chk.sv
module irqd_chk
  import irqd_pkg::*;
#(
  parameter int NUM_IRQ = 96,
  parameter int NUM_CPU = 2,
  parameter int RSV_LO  = 16,
  parameter int RSV_HI  = 26,
  parameter int ADDR_W  = 8,
  parameter int ID_W    = 7
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          bus_we,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic [WORD_W-1:0]             bus_wdata,
  input logic                          dist_en,
  input logic [NUM_CPU-1:0]            cpu_if_en,
  input logic [NUM_CPU-1:0][PRIO_W-1:0] pmask,
  input logic [NUM_CPU-1:0][PRIO_W-1:0] win_prio,
  input logic [NUM_IRQ-1:0]            pending,
  input logic [NUM_IRQ-1:0]            enable,
  input logic [NUM_CPU-1:0]            cpu_irq,
  input logic [NUM_CPU*ID_W-1:0]       cpu_id
);
  AST_RSV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    pending[RSV_HI:RSV_LO] == '0); // R4

  AST_SETEN_W1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && int'(bus_addr) == A_SETEN) |=>
      ((enable[31:0] & $past(bus_wdata)) == $past(bus_wdata))); // R2

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
    AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq[c] |-> dist_en); // R6
    AST_IF_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq[c] |-> cpu_if_en[c]); // R7
    AST_UNDER_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq[c] |-> (win_prio[c] < pmask[c])); // R8
    AST_WINNER_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq[c] |-> (pending[cpu_id[c*ID_W +: ID_W]] && enable[cpu_id[c*ID_W +: ID_W]])); // R9
    AST_IDLE_ID: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_irq[c] |-> (cpu_id[c*ID_W +: ID_W] == '0)); // R1
  end
endmodule

bind irq_distributor irqd_chk #(
  .NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .RSV_LO(RSV_LO), .RSV_HI(RSV_HI),
  .ADDR_W(ADDR_W), .ID_W(ID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .dist_en(dist_en), .cpu_if_en(cpu_if_en), .pmask(pmask), .win_prio(win_prio),
  .pending(pending), .enable(enable), .cpu_irq(cpu_irq), .cpu_id(cpu_id)
);

// File: tb/sim_irq_distributor.sv
module sim_irq_distributor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] irq_in = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  cpu_irq;
  logic [13:0] cpu_id;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  irq_distributor u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_irq(cpu_irq), .cpu_id(cpu_id)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int adr, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 8'(adr); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  // R11: data is captured at the edge that samples bus_re and read one cycle later
  task automatic rd(input int adr, output logic [31:0] d);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = 8'(adr);
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 cpu_irq", {30'd0, cpu_irq}, 32'd0);
    check("R1 cpu_id", {18'd0, cpu_id}, 32'd0);
    rd('h10, d); check("R1 enable word0", d, 32'd0);
    rd('h1D, d); check("R1 R11 pending word1", d, 32'd0);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    wr('h11, 32'h0000_00F0);
    rd('h11, d); check("R2 set-enable readback", d, 32'h0000_00F0);
    rd('h15, d); check("R2 clear-enable readback", d, 32'h0000_00F0);
    wr('h15, 32'h0000_0010);
    rd('h11, d); check("R2 clear-enable one bit", d, 32'h0000_00E0);
    wr('h11, 32'h0); wr('h15, 32'h0);
    rd('h11, d); check("R2 zero writes no effect", d, 32'h0000_00E0);
    wr('h15, 32'h0000_00E0);
  endtask

  task automatic t_edge;
    logic [31:0] d;
    wr('h22, 32'h0002_0000); // source 40 edge-triggered
    @(negedge clk); irq_in[40] = 1'b1;
    @(negedge clk); irq_in[40] = 1'b0;
    idle(2);
    rd('h1D, d); check("R3 edge latched after line falls", d, 32'h0000_0100);
    wr('h18, 32'hFFFF_FFFF); wr('h19, 32'h0);
    rd('h1D, d); check("R4 zero clear-pending no effect", d, 32'h0000_0100);
    wr('h19, 32'h0000_0100);
    rd('h1D, d); check("R4 clear-pending", d, 32'h0);
  endtask

  task automatic t_level;
    logic [31:0] d;
    @(negedge clk); irq_in[41] = 1'b1;
    idle(2);
    rd('h1D, d); check("R3 level pending", d, 32'h0000_0200);
    wr('h19, 32'h0000_0200);
    rd('h1D, d); check("R3 R4 level reasserts over clear", d, 32'h0000_0200);
    @(negedge clk); irq_in[41] = 1'b0;
    wr('h19, 32'h0000_0200);
    rd('h1D, d); check("R3 level cleared when low", d, 32'h0);
  endtask

  task automatic t_reserved;
    logic [31:0] d;
    @(negedge clk); irq_in[26:0] = '1;
    idle(3);
    rd('h1C, d); check("R4 reserved and software lines ignored", d, 32'h0);
    @(negedge clk); irq_in[26:0] = '0;
  endtask

  task automatic t_route;
    wr('h08, 32'hF0); wr('h09, 32'hF0);
    wr('h04, 1); wr('h05, 1);
    wr('h4C, 32'h0080_0000); // prio of 50 = 0x80
    wr('h6C, 32'h0001_0000); // target of 50 = CPU0
    wr('h11, 32'h0004_0000); // enable 50
    @(negedge clk); irq_in[50] = 1'b1;
    idle(2);
    check("R6 off blocks", {30'd0, cpu_irq}, 32'd0);
    wr('h00, 1);
    check("R10 route to cpu0", {30'd0, cpu_irq}, 32'd1);
    check("R9 cpu0 id", {25'd0, cpu_id[6:0]}, 32'd50);
    wr('h6C, 32'h0002_0000);
    check("R10 route to cpu1", {30'd0, cpu_irq}, 32'd2);
    check("R9 cpu1 id", {25'd0, cpu_id[13:7]}, 32'd50);
    wr('h00, 0);
    check("R6 global off", {30'd0, cpu_irq}, 32'd0);
    wr('h00, 1); wr('h05, 0);
    check("R7 interface off", {30'd0, cpu_irq}, 32'd0);
    wr('h05, 1); wr('h09, 32'h80);
    check("R8 equal to threshold blocked", {30'd0, cpu_irq}, 32'd0);
    wr('h09, 32'h81);
    check("R8 below threshold passes", {30'd0, cpu_irq}, 32'd2);
  endtask

  task automatic t_prio;
    wr('h4D, 32'h4000_0000); // 55 prio 0x40
    wr('h4F, 32'h0000_0040); // 60 prio 0x40
    wr('h51, 32'h0020_0000); // 70 prio 0x20
    wr('h6D, 32'h0300_0000); // 55 -> both
    wr('h6F, 32'h0000_0003); // 60 -> both
    wr('h71, 32'h0001_0000); // 70 -> CPU0
    wr('h11, 32'h1080_0000); wr('h12, 32'h0000_0040);
    @(negedge clk); irq_in[55] = 1'b1; irq_in[60] = 1'b1; irq_in[70] = 1'b1;
    idle(2);
    check("R9 cpu0 most urgent", {25'd0, cpu_id[6:0]}, 32'd70);
    check("R9 cpu1 tie lowest id", {25'd0, cpu_id[13:7]}, 32'd55);
    check("R10 both asserted", {30'd0, cpu_irq}, 32'd3);
  endtask

  task automatic t_sgi;
    wr('h41, 32'h0000_1000); // 5 prio 0x10
    wr('h10, 32'h0000_0020); // enable 5
    wr('h0C, 32'h0002_0005); // raise 5 toward CPU1
    idle(1);
    check("R5 sgi to cpu1", {25'd0, cpu_id[13:7]}, 32'd5);
    check("R5 cpu0 untouched", {25'd0, cpu_id[6:0]}, 32'd70);
    wr('h18, 32'h0000_0020);
    check("R4 R5 sgi cleared", {25'd0, cpu_id[13:7]}, 32'd55);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    idle(1);
    t_reset(); t_enable(); t_edge(); t_level(); t_reserved(); t_route(); t_prio(); t_sgi();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule